// File: doc/BRIEF.md
# Reconfigurable-Edge Bit-Serial Cell Grid

This block is a ROWS x COLS grid of one-bit processing cells that all execute one broadcast instruction per clock. Each cell holds four one-bit registers (NS, EW, C and CM), a private one-bit-wide memory addressed by `addr_i`, and a one-bit full adder/subtractor. Cells exchange NS values with their north and south neighbours and EW values with their east and west neighbours. A second vertical path runs through the CM registers only. It carries a COLS-bit word in on `south_i` at the bottom row (row ROWS-1) and out on `north_o` at the top row (row 0). This path moves independently of the arithmetic.

The runtime input `chain_i` picks the horizontal topology. With `chain_i` low, each row closes on itself, and together with the vertical wrap this makes a torus. With `chain_i` high, the rows are stitched end to end into one long acyclic string of ROWS*COLS cells, and the two outermost ends of that string read zero. The vertical NS links stay wrapped in chain mode while the parameter `CHAIN_VWRAP` is 1. An external sequencer supplies the instruction stream, which is outside this block.

The data buses have no flow control. `south_i` is sampled only on cycles that shift CM, and `north_o` is a plain registered view of the top row. For this reason the host must pace the words itself rather than rely on a valid/ready handshake.

Top module: `ca_grid`

## Requirements
- R1: While `rst_n` is low, every NS, EW, C and CM bit and every memory bit clears to 0, so `north_o` reads all zeros after reset.
- R2: Field `op_i[12:11]` drives CM: 0 keep, 1 load the cell's memory bit at `addr_i`, 2 take the CM of the cell directly south, 3 clear. The bottom row takes `south_i[c]`, and `north_o[c]` is the CM of row 0, column c. A word therefore reaches `north_o` after ROWS shifts.
- R3: The CM field acts in the same cycle as the NS, EW, C and memory fields, with no interaction between them.
- R4: Field `op_i[8:6]` drives NS: 0 keep, 1 memory, 2 NS of the north neighbour, 3 NS of the south neighbour, 4 EW, 5 C, 6 zero, 7 keep. Row 0's north neighbour is row ROWS-1 and the reverse, in both modes when `CHAIN_VWRAP` is 1.
- R5: Field `op_i[5:3]` drives EW: 0 keep, 1 memory, 2 EW of the east neighbour, 3 EW of the west neighbour, 4 NS, 5 C, 6 zero, 7 keep. With `chain_i`=0, column COLS-1 and column 0 of the same row are neighbours. Column 0 is the west end.
- R6: With `chain_i`=1, the west neighbour of (r,0) is (r-1,COLS-1) and the east neighbour of (r,COLS-1) is (r+1,0). The west input of (0,0) and the east input of (ROWS-1,COLS-1) read 0.
- R7: Field `op_i[2:0]` drives C: 0 keep, 1 memory, 2 NS, 3 EW, 4 carry = majority(NS,EW,C), 5 borrow of NS-EW-C = (!NS&(EW|C))|(EW&C), 6 zero, 7 one.
- R8: With `wr_i`=1, the memory bit at `addr_i` of every cell takes the source chosen by `op_i[10:9]`: 0 its own value, 1 CM, 2 C, 3 sum NS^EW^C. With `wr_i`=0, memory is unchanged. Every source in a cycle uses values from before the clock edge.
- R9: Every cell applies the same instruction in the same cycle, whatever mix of fields, addresses, write strobes and modes arrives.
- R10: `south_i` has no effect in any cycle whose CM field is not 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 13 | Broadcast instruction word |
| addr_i | input | AW | Broadcast memory bit address |
| wr_i | input | 1 | Memory write strobe |
| chain_i | input | 1 | 1 = rows chained into one string, 0 = torus |
| south_i | input | COLS | Word entering the bottom row |
| north_o | output | COLS | CM bits of the top row |

## Verification
The bench drives the wrap corners hardest. A grid with a wrong edge link would deliver a bit from the wrong row or column at column 0, column COLS-1, row 0 or row ROWS-1. A grid that mishandles chain mode would leak a wrapped value into the two free ends, or would stitch rows in the wrong order. Shifts issued together with arithmetic would expose a design that stalls CM during ALU work. Garbage on `south_i` during non-shift cycles would expose an unguarded capture. Borrow and carry are checked on patterns that cover all eight operand combinations, where a swapped subtraction order flips the result.

// File: rtl/ca_pkg.sv
package ca_pkg;
  localparam int OP_W = 13;

  typedef enum logic [1:0] {CM_KEEP, CM_MEM, CM_SHIFT, CM_CLR} cm_sel_e;
  typedef enum logic [1:0] {WB_SELF, WB_CM, WB_C, WB_SUM} wb_sel_e;
  typedef enum logic [2:0] {NS_KEEP, NS_MEM, NS_FROM_N, NS_FROM_S,
                            NS_EW, NS_C, NS_CLR, NS_HOLD} ns_sel_e;
  typedef enum logic [2:0] {EW_KEEP, EW_MEM, EW_FROM_E, EW_FROM_W,
                            EW_NS, EW_C, EW_CLR, EW_HOLD} ew_sel_e;
  typedef enum logic [2:0] {C_KEEP, C_MEM, C_NS, C_EW,
                            C_CY, C_BW, C_CLR, C_SET} c_sel_e;

  typedef struct packed {
    cm_sel_e cm;
    wb_sel_e wb;
    ns_sel_e ns;
    ew_sel_e ew;
    c_sel_e  c;
  } op_t;

  typedef struct packed {
    logic from_n;
    logic from_s;
    logic from_e;
    logic from_w;
    logic from_below;
  } nbr_t;
endpackage

// File: rtl/ca_alu.sv
module ca_alu (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic cy,
  output logic bw
);
  assign sum = a ^ b ^ cin;
  assign cy  = (a & b) | (a & cin) | (b & cin);
  assign bw  = (~a & (b | cin)) | (b & cin);
endmodule

// File: rtl/ca_cell.sv
module ca_cell
  import ca_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_t           op,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  nbr_t          nbr,
  output logic          ns_q,
  output logic          ew_q,
  output logic          cm_q
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] mem_q;
  logic c_q;
  logic rd, sum, cy, bw;
  logic ns_d, ew_d, c_d, cm_d, wb_d;

  assign rd = mem_q[addr];

  ca_alu u_alu (
    .a   (ns_q),
    .b   (ew_q),
    .cin (c_q),
    .sum (sum),
    .cy  (cy),
    .bw  (bw)
  );

  always_comb begin
    case (op.ns)
      NS_MEM:    ns_d = rd;
      NS_FROM_N: ns_d = nbr.from_n;
      NS_FROM_S: ns_d = nbr.from_s;
      NS_EW:     ns_d = ew_q;
      NS_C:      ns_d = c_q;
      NS_CLR:    ns_d = 1'b0;
      default:   ns_d = ns_q;
    endcase
  end

  always_comb begin
    case (op.ew)
      EW_MEM:    ew_d = rd;
      EW_FROM_E: ew_d = nbr.from_e;
      EW_FROM_W: ew_d = nbr.from_w;
      EW_NS:     ew_d = ns_q;
      EW_C:      ew_d = c_q;
      EW_CLR:    ew_d = 1'b0;
      default:   ew_d = ew_q;
    endcase
  end

  always_comb begin
    case (op.c)
      C_MEM:   c_d = rd;
      C_NS:    c_d = ns_q;
      C_EW:    c_d = ew_q;
      C_CY:    c_d = cy;
      C_BW:    c_d = bw;
      C_CLR:   c_d = 1'b0;
      C_SET:   c_d = 1'b1;
      default: c_d = c_q;
    endcase
  end

  always_comb begin
    case (op.cm)
      CM_MEM:   cm_d = rd;
      CM_SHIFT: cm_d = nbr.from_below;
      CM_CLR:   cm_d = 1'b0;
      default:  cm_d = cm_q;
    endcase
  end

  always_comb begin
    case (op.wb)
      WB_CM:   wb_d = cm_q;
      WB_C:    wb_d = c_q;
      WB_SUM:  wb_d = sum;
      default: wb_d = rd;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q  <= 1'b0;
      ew_q  <= 1'b0;
      c_q   <= 1'b0;
      cm_q  <= 1'b0;
      mem_q <= '0;
    end else begin
      ns_q <= ns_d;
      ew_q <= ew_d;
      c_q  <= c_d;
      cm_q <= cm_d;
      if (wr) mem_q[addr] <= wb_d;
    end
  end

  // R7
  c_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op.c == C_SET) |=> c_q);

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr) |=> $stable(mem_q));

  // R2
  cm_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op.cm == CM_SHIFT) |=> (cm_q == $past(nbr.from_below)));

  // R5
  ew_east_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op.ew == EW_FROM_E) |=> (ew_q == $past(nbr.from_e)));
endmodule

// File: rtl/ca_grid.sv
module ca_grid
  import ca_pkg::*;
#(
  parameter int ROWS        = 4,
  parameter int COLS        = 4,
  parameter int AW          = 5,
  parameter bit CHAIN_VWRAP = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_i,
  input  logic            chain_i,
  input  logic [COLS-1:0] south_i,
  output logic [COLS-1:0] north_o
);
  localparam int LAST_R = ROWS - 1;
  localparam int LAST_C = COLS - 1;

  op_t  op;
  logic ns_a [ROWS][COLS];
  logic ew_a [ROWS][COLS];
  logic cm_a [ROWS][COLS];

  assign op = op_t'(op_i);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic n_v, s_v, e_v, w_v, b_v;

      if (r == 0) begin : g_ntop
        assign n_v = (chain_i && !CHAIN_VWRAP) ? 1'b0 : ns_a[LAST_R][c];
      end else begin : g_nin
        assign n_v = ns_a[r-1][c];
      end

      if (r == LAST_R) begin : g_sbot
        assign s_v = (chain_i && !CHAIN_VWRAP) ? 1'b0 : ns_a[0][c];
        assign b_v = south_i[c];
      end else begin : g_sin
        assign s_v = ns_a[r+1][c];
        assign b_v = cm_a[r+1][c];
      end

      if (c < LAST_C) begin : g_ein
        assign e_v = ew_a[r][c+1];
      end else if (r < LAST_R) begin : g_eedge
        assign e_v = chain_i ? ew_a[r+1][0] : ew_a[r][0];
      end else begin : g_etail
        assign e_v = chain_i ? 1'b0 : ew_a[r][0];
      end

      if (c > 0) begin : g_win
        assign w_v = ew_a[r][c-1];
      end else if (r > 0) begin : g_wedge
        assign w_v = chain_i ? ew_a[r-1][LAST_C] : ew_a[r][LAST_C];
      end else begin : g_whead
        assign w_v = chain_i ? 1'b0 : ew_a[r][LAST_C];
      end

      ca_cell #(.AW(AW)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .addr  (addr_i),
        .wr    (wr_i),
        .nbr   ({n_v, s_v, e_v, w_v, b_v}),
        .ns_q  (ns_a[r][c]),
        .ew_q  (ew_a[r][c]),
        .cm_q  (cm_a[r][c])
      );
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_out
    assign north_o[c] = cm_a[0][c];
  end

  // R2
  north_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op.cm == CM_KEEP) |=> $stable(north_o));

  // R6
  chain_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_i && op.ew == EW_FROM_W) |=> !ew_a[0][0]);

  // R5
  torus_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_i && op.ew == EW_FROM_W) |=> (ew_a[0][0] == $past(ew_a[0][LAST_C])));

  // R4
  vert_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op.ns == NS_FROM_N && (CHAIN_VWRAP || !chain_i))
      |=> (ns_a[0][0] == $past(ns_a[LAST_R][0])));
endmodule

// File: tb/sim_ca_grid.sv
module sim_ca_grid;
  import ca_pkg::*;

  localparam int  ROWS  = 4;
  localparam int  COLS  = 4;
  localparam int  AW    = 5;
  localparam int  DEPTH = 1 << AW;
  localparam time TCK   = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [OP_W-1:0] op = '0;
  logic [AW-1:0]   addr = '0;
  logic            wr = 1'b0;
  logic            chain = 1'b0;
  logic [COLS-1:0] south = '0;
  logic [COLS-1:0] north;

  ca_grid #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op),
    .addr_i  (addr),
    .wr_i    (wr),
    .chain_i (chain),
    .south_i (south),
    .north_o (north)
  );

  always #(TCK/2) clk = ~clk;

  typedef struct {
    logic [COLS-1:0] exp;
    string           tag;
  } item_t;

  item_t q[$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  bit m_ns [ROWS][COLS];
  bit m_ew [ROWS][COLS];
  bit m_c  [ROWS][COLS];
  bit m_cm [ROWS][COLS];
  bit m_mem[ROWS][COLS][DEPTH];

  function automatic logic [OP_W-1:0] mk(cm_sel_e m, wb_sel_e b, ns_sel_e n,
                                         ew_sel_e e, c_sel_e k);
    return {m, b, n, e, k};
  endfunction

  // Reference behaviour written from the requirement encodings
  function automatic void model_step(logic [OP_W-1:0] o, int a, bit w, bit ch,
                                     logic [COLS-1:0] s);
    bit t_ns[ROWS][COLS];
    bit t_ew[ROWS][COLS];
    bit t_c [ROWS][COLS];
    bit t_cm[ROWS][COLS];
    int cmf = int'(o[12:11]);
    int wbf = int'(o[10:9]);
    int nsf = int'(o[8:6]);
    int ewf = int'(o[5:3]);
    int cf  = int'(o[2:0]);
    for (int r = 0; r < ROWS; r++) begin
      for (int k = 0; k < COLS; k++) begin
        bit rd = m_mem[r][k][a];
        bit n0 = m_ns[r][k];
        bit e0 = m_ew[r][k];
        bit c0 = m_c[r][k];
        bit nv = m_ns[(r+ROWS-1)%ROWS][k];
        bit sv = m_ns[(r+1)%ROWS][k];
        bit ev, wv, bel, sm, cyv, bwv, wbv;
        if (k < COLS-1) ev = m_ew[r][k+1];
        else if (!ch) ev = m_ew[r][0];
        else ev = (r < ROWS-1) ? m_ew[r+1][0] : 1'b0;
        if (k > 0) wv = m_ew[r][k-1];
        else if (!ch) wv = m_ew[r][COLS-1];
        else wv = (r > 0) ? m_ew[r-1][COLS-1] : 1'b0;
        bel = (r == ROWS-1) ? s[k] : m_cm[r+1][k];
        sm  = n0 ^ e0 ^ c0;
        cyv = (n0 + e0 + c0) >= 2;
        bwv = (int'(n0) - int'(e0) - int'(c0)) < 0;
        case (nsf)
          1: t_ns[r][k] = rd;  2: t_ns[r][k] = nv;  3: t_ns[r][k] = sv;
          4: t_ns[r][k] = e0;  5: t_ns[r][k] = c0;  6: t_ns[r][k] = 1'b0;
          default: t_ns[r][k] = n0;
        endcase
        case (ewf)
          1: t_ew[r][k] = rd;  2: t_ew[r][k] = ev;  3: t_ew[r][k] = wv;
          4: t_ew[r][k] = n0;  5: t_ew[r][k] = c0;  6: t_ew[r][k] = 1'b0;
          default: t_ew[r][k] = e0;
        endcase
        case (cf)
          1: t_c[r][k] = rd;   2: t_c[r][k] = n0;   3: t_c[r][k] = e0;
          4: t_c[r][k] = cyv;  5: t_c[r][k] = bwv;  6: t_c[r][k] = 1'b0;
          7: t_c[r][k] = 1'b1;
          default: t_c[r][k] = c0;
        endcase
        case (cmf)
          1: t_cm[r][k] = rd;  2: t_cm[r][k] = bel;  3: t_cm[r][k] = 1'b0;
          default: t_cm[r][k] = m_cm[r][k];
        endcase
        case (wbf)
          1: wbv = m_cm[r][k];  2: wbv = c0;  3: wbv = sm;
          default: wbv = rd;
        endcase
        if (w) m_mem[r][k][a] = wbv;
      end
    end
    m_ns = t_ns; m_ew = t_ew; m_c = t_c; m_cm = t_cm;
  endfunction

  task automatic step(input logic [OP_W-1:0] o, input int a, input bit w,
                      input bit ch, input logic [COLS-1:0] s, input string tag);
    item_t it;
    @(negedge clk);
    op = o; addr = AW'(a); wr = w; chain = ch; south = s;
    model_step(o, a, w, ch, s);
    for (int k = 0; k < COLS; k++) it.exp[k] = m_cm[0][k];
    it.tag = tag;
    q.push_back(it);
  endtask

  // Scoreboard monitor: compares one expected word per clock
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        vectors++;
        if (north !== it.exp) begin
          miscompares++;
          $display("FAIL %s: north_o=%b expected %b", it.tag, north, it.exp);
        end
      end
    end
  end

  // Bring NS (src 0), EW (src 1) or C (src 2) out through memory and CM
  task automatic dump(input int src, input bit ch, input string tag);
    if (src == 0) step(mk(CM_KEEP, WB_SELF, NS_KEEP, EW_KEEP, C_NS), 0, 0, ch, '0, tag);
    if (src == 1) step(mk(CM_KEEP, WB_SELF, NS_KEEP, EW_KEEP, C_EW), 0, 0, ch, '0, tag);
    step(mk(CM_KEEP, WB_C, NS_KEEP, EW_KEEP, C_KEEP), 31, 1, ch, '0, tag);
    step(mk(CM_MEM, WB_SELF, NS_KEEP, EW_KEEP, C_KEEP), 31, 0, ch, '0, tag);
    for (int i = 0; i < ROWS; i++)
      step(mk(CM_SHIFT, WB_SELF, NS_KEEP, EW_KEEP, C_KEEP), 0, 0, ch,
           COLS'($urandom), tag);
  endtask

  task automatic load_mem(input int a, input logic [4*COLS-1:0] pat, input string tag);
    for (int i = 0; i < ROWS; i++) begin
      step(mk(CM_SHIFT, WB_SELF, NS_KEEP, EW_KEEP, C_KEEP), 0, 0, 0,
           pat[(i%4)*COLS +: COLS], tag);
      // R10: garbage on the south bus while CM holds
      step(mk(CM_KEEP, WB_SELF, NS_KEEP, EW_KEEP, C_KEEP), 0, 0, 0,
           COLS'($urandom), "R10 south ignored");
    end
    step(mk(CM_KEEP, WB_CM, NS_KEEP, EW_KEEP, C_KEEP), a, 1, 0, '0, tag);
  endtask

  initial begin
    #(TCK * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung, expected run to complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (north !== '0) begin
      miscompares++;
      $display("FAIL R1 reset: north_o=%b expected %b", north, {COLS{1'b0}});
    end
    rst_n = 1'b1;

    // R2: words walk north one row per shift; R8: write from CM
    load_mem(3, 16'hB61C, "R2 shift path");
    // R8: write strobe low leaves memory alone
    step(mk(CM_KEEP, WB_CM, NS_KEEP, EW_KEEP, C_KEEP), 4, 0, 0, '0, "R8 no write");
    step(mk(CM_MEM, WB_SELF, NS_KEEP, EW_KEEP, C_KEEP), 4, 0, 0, '0, "R8 no write");
    for (int i = 0; i < ROWS; i++)
      step(mk(CM_SHIFT, WB_SELF, NS_KEEP, EW_KEEP, C_KEEP), 0, 0, 0, 4'h9, "R8 readback");
    step(mk(CM_CLR, WB_SELF, NS_KEEP, EW_KEEP, C_KEEP), 0, 0, 0, '0, "R2 clear");

    // R4: vertical moves with wrap
    step(mk(CM_KEEP, WB_SELF, NS_MEM, EW_KEEP, C_KEEP), 3, 0, 0, '0, "R4 load");
    step(mk(CM_KEEP, WB_SELF, NS_FROM_N, EW_KEEP, C_KEEP), 0, 0, 0, '0, "R4 from north");
    dump(0, 0, "R4 north wrap");
    step(mk(CM_KEEP, WB_SELF, NS_FROM_S, EW_KEEP, C_KEEP), 0, 0, 1, '0, "R4 from south");
    step(mk(CM_KEEP, WB_SELF, NS_FROM_S, EW_KEEP, C_KEEP), 0, 0, 1, '0, "R4 from south");
    dump(0, 1, "R4 chain vertical wrap");

    // R5: horizontal torus
    step(mk(CM_KEEP, WB_SELF, NS_KEEP, EW_MEM, C_KEEP), 3, 0, 0, '0, "R5 load");
    step(mk(CM_KEEP, WB_SELF, NS_KEEP, EW_FROM_E, C_KEEP), 0, 0, 0, '0, "R5 from east");
    dump(1, 0, "R5 east wrap");
    step(mk(CM_KEEP, WB_SELF, NS_KEEP, EW_FROM_W, C_KEEP), 0, 0, 0, '0, "R5 from west");
    step(mk(CM_KEEP, WB_SELF, NS_KEEP, EW_FROM_W, C_KEEP), 0, 0, 0, '0, "R5 from west");
    dump(1, 0, "R5 west wrap");

    // R6: chained rows with zero ends
    load_mem(9, 16'hFFFF, "R6 load ones");
    step(mk(CM_KEEP, WB_SELF, NS_KEEP, EW_MEM, C_KEEP), 9, 0, 1, '0, "R6 load");
    for (int i = 0; i < 3; i++)
      step(mk(CM_KEEP, WB_SELF, NS_KEEP, EW_FROM_W, C_KEEP), 0, 0, 1, '0, "R6 west head zero");
    dump(1, 1, "R6 chain west");
    step(mk(CM_KEEP, WB_SELF, NS_KEEP, EW_MEM, C_KEEP), 3, 0, 1, '0, "R6 load");
    for (int i = 0; i < 5; i++)
      step(mk(CM_KEEP, WB_SELF, NS_KEEP, EW_FROM_E, C_KEEP), 0, 0, 1, '0, "R6 east tail zero");
    dump(1, 1, "R6 chain east");

    // R7: carry and borrow over all operand combinations
    load_mem(5, 16'hF0F0, "R7 load a");
    load_mem(6, 16'hCCCC, "R7 load b");
    load_mem(7, 16'hAAAA, "R7 load c");
    step(mk(CM_KEEP, WB_SELF, NS_MEM, EW_KEEP, C_KEEP), 5, 0, 0, '0, "R7 ns");
    step(mk(CM_KEEP, WB_SELF, NS_KEEP, EW_MEM, C_KEEP), 6, 0, 0, '0, "R7 ew");
    step(mk(CM_KEEP, WB_SELF, NS_KEEP, EW_KEEP, C_MEM), 7, 0, 0, '0, "R7 c");
    step(mk(CM_KEEP, WB_SUM, NS_KEEP, EW_KEEP, C_CY), 8, 1, 0, '0, "R7 carry");
    dump(2, 0, "R7 carry out");
    step(mk(CM_KEEP, WB_SELF, NS_KEEP, EW_KEEP, C_MEM), 7, 0, 0, '0, "R7 c");
    step(mk(CM_KEEP, WB_SELF, NS_KEEP, EW_KEEP, C_BW), 0, 0, 0, '0, "R7 borrow");
    dump(2, 0, "R7 borrow out");
    step(mk(CM_MEM, WB_SELF, NS_KEEP, EW_KEEP, C_SET), 8, 0, 0, '0, "R8 sum readback");
    for (int i = 0; i < ROWS; i++)
      step(mk(CM_SHIFT, WB_SELF, NS_EW, EW_NS, C_KEEP), 0, 0, 0, '0, "R8 sum out");
    dump(2, 0, "R7 set");

    // R3: shift concurrent with every other field
    for (int i = 0; i < 8; i++)
      step(mk(CM_SHIFT, WB_SUM, NS_FROM_S, EW_FROM_E, C_CY), i, 1, i % 2,
           COLS'(i * 5), "R3 concurrent");
    dump(0, 0, "R3 concurrent ns");

    // R9: broadcast behaviour under mixed random instructions
    for (int i = 0; i < 600; i++)
      step(OP_W'($urandom), $urandom % 8, 1'($urandom), 1'($urandom),
           COLS'($urandom), "R9 broadcast random");
    for (int i = 0; i < 3; i++) dump(i, 1'(i), "R9 final state");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule